// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a general-purpose I/O peripheral with up to 32 pins behind a plain 32-bit register bus. Each pin owns an 8-bit configuration word. The word turns on input sampling, the output register path, the output driver and the pin interrupt, and it selects one of five trigger types. Software reads pin levels through a read-only input register and drives pins through a read/write output register. It can also use write-only set and clear registers to update single bits without a read-modify-write.

Inputs pass through a multi-flop synchroniser. Interrupt causes collect in a sticky status register that software clears by writing ones. All status bits are ORed into one interrupt line. The bus has no handshake: a write takes effect on the clock edge where write enable is high. Read data appears one cycle after the address is presented.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every register reads zero, `pin_o`, `pin_oe_o` and `irq_o` are low, and all pins are unconfigured.
- R2: The configuration word of pin p sits at byte address 4*p. Its fields are: bit 0 output-register enable, bit 1 input enable, bit 2 output-buffer enable, bit 3 interrupt enable, bits 7:5 trigger code. Bit 4 and bits 31:8 read as zero.
- R3: The output register at 0x88 is readable and writable. `pin_o[p]` equals output bit p when config bit 0 is set, and 0 otherwise. `pin_oe_o[p]` is high only when config bits 0 and 2 are both set.
- R4: Writing to 0xA4 forces high the output bits whose data bits are 1. Writing to 0xA0 forces them low. Zero data bits leave the output unchanged, and both addresses read as zero.
- R5: The input register at 0x84 returns the two-flop-synchronised pin levels ANDed with each pin's input-enable bit. A pin change becomes readable only when the read is issued at least two clock edges after the change.
- R6: Trigger code 2 latches a rising edge, code 3 a falling edge and code 4 either edge, comparing the synchronised value with its previous sample. The status bit is set on the third clock edge after the pin change. A pin with config bit 3 clear never sets its status bit.
- R7: Trigger code 0 (level high) and code 1 (level low) set the status bit on every cycle the level holds, so a clear during that time has no lasting effect. Codes 5 to 7 never set status.
- R8: The status register at 0x80 is sticky. Writing 1 to a bit clears it, and 0 bits are left as they are. `irq_o` is high while any status bit is set.
- R9: Reads of unused or unaligned addresses, of configuration words above the pin count, and of 0x8C to 0x9C return zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 8 | Byte address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after address |
| pin_i | input | NUM_PINS | Pin input levels (asynchronous) |
| pin_o | output | NUM_PINS | Pin output values |
| pin_oe_o | output | NUM_PINS | Pin output-buffer enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with NUM_PINS = 8 and SYNC_STAGES = 2. With eight pins, configuration words 8 to 31 fall in the reserved space, so R9 can be checked through ordinary reads and writes. Output and status values are at most 8 bits wide, which makes it visible that the upper bits of written data are dropped. The two-stage synchroniser fixes when an input becomes readable and when a status bit is set, and the bench checks the interrupt line on each of those edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MAX_PINS = 32;

  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_IN   = 8'h84;
  localparam logic [ADDR_W-1:0] OFF_OUT  = 8'h88;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_SET  = 8'hA4;

  typedef enum logic [2:0] {
    TRIG_LVL_HI = 3'd0,
    TRIG_LVL_LO = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef struct packed {
    logic [2:0] trig;
    logic       irq_en;
    logic       obuf_en;
    logic       in_en;
    logic       oreg_en;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  pin_cfg_t [NUM_PINS-1:0] cfg_i,
  input  logic     [NUM_PINS-1:0] cur_i,
  input  logic     [NUM_PINS-1:0] prev_i,
  output logic     [NUM_PINS-1:0] hit_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic raw;
    always_comb begin
      case (cfg_i[p].trig)
        TRIG_LVL_HI: raw = cur_i[p];
        TRIG_LVL_LO: raw = cfg_i[p].in_en & ~cur_i[p];
        TRIG_RISE:   raw = cur_i[p] & ~prev_i[p];
        TRIG_FALL:   raw = ~cur_i[p] & prev_i[p];
        TRIG_BOTH:   raw = cur_i[p] ^ prev_i[p];
        default:     raw = 1'b0;  // codes 5..7 reserved
      endcase
    end
    assign hit_o[p] = raw & cfg_i[p].irq_en;
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam logic [5:0] PIN_LIM = 6'(NUM_PINS);

  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0] out_q, status_q, prev_q;
  logic [NUM_PINS-1:0] sync_w, in_val, hit_w;
  logic [NUM_PINS-1:0] oreg_mask, obuf_mask, in_mask, irq_en_mask;
  logic [ADDR_W-1:0]   addr_al;
  logic [4:0]          pin_idx;
  logic                aligned, is_cfg;
  logic [DATA_W-1:0]   rd_d;

  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign addr_al = {bus_addr_i[ADDR_W-1:2], 2'b00};
  assign pin_idx = bus_addr_i[6:2];
  assign is_cfg  = aligned && !bus_addr_i[7] && ({1'b0, pin_idx} < PIN_LIM);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[p] <= '0;
      else if (bus_we_i && is_cfg && pin_idx == 5'(p))
        cfg_q[p] <= {bus_wdata_i[7:5], bus_wdata_i[3:0]};
    end
    assign oreg_mask[p]   = cfg_q[p].oreg_en;
    assign obuf_mask[p]   = cfg_q[p].obuf_en;
    assign in_mask[p]     = cfg_q[p].in_en;
    assign irq_en_mask[p] = cfg_q[p].irq_en;
  end

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  assign in_val = sync_w & in_mask;

  gpio_trig_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .cfg_i (cfg_q),
    .cur_i (in_val),
    .prev_i(prev_q),
    .hit_o (hit_w)
  );

  logic wr_stat, wr_out, wr_set, wr_clr;
  assign wr_stat = bus_we_i && aligned && addr_al == OFF_STAT;
  assign wr_out  = bus_we_i && aligned && addr_al == OFF_OUT;
  assign wr_set  = bus_we_i && aligned && addr_al == OFF_SET;
  assign wr_clr  = bus_we_i && aligned && addr_al == OFF_CLR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
      out_q    <= '0;
    end else begin
      prev_q   <= in_val;
      // hits win over a same-cycle clear so live levels stay latched
      status_q <= (status_q & ~(wr_stat ? bus_wdata_i[NUM_PINS-1:0] : '0)) | hit_w;
      if (wr_out)      out_q <= bus_wdata_i[NUM_PINS-1:0];
      else if (wr_clr) out_q <= out_q & ~bus_wdata_i[NUM_PINS-1:0];
      else if (wr_set) out_q <= out_q | bus_wdata_i[NUM_PINS-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (is_cfg) begin
      for (int p = 0; p < NUM_PINS; p++)
        if (pin_idx == 5'(p)) rd_d[7:0] = {cfg_q[p].trig, 1'b0, cfg_q[p][3:0]};
    end else if (aligned) begin
      case (addr_al)
        OFF_STAT: rd_d[NUM_PINS-1:0] = status_q;
        OFF_IN:   rd_d[NUM_PINS-1:0] = in_val;
        OFF_OUT:  rd_d[NUM_PINS-1:0] = out_q;
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else         bus_rdata_o <= rd_d;
  end

  assign pin_o    = out_q & oreg_mask;
  assign pin_oe_o = oreg_mask & obuf_mask;
  assign irq_o    = |status_q;
endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic                bus_we_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] out_q,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] irq_en_mask
);
  logic wr_set, wr_clr, wr_stat, wr_rsvd;
  assign wr_set  = bus_we_i && bus_addr_i == OFF_SET;
  assign wr_clr  = bus_we_i && bus_addr_i == OFF_CLR;
  assign wr_stat = bus_we_i && bus_addr_i == OFF_STAT;
  assign wr_rsvd = bus_we_i && bus_addr_i == 8'h8C;

  AST_STATUS_NEEDS_IRQ_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q & ~$past(status_q) & ~$past(irq_en_mask)) == '0); // R6

  AST_STATUS_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~status_q & $past(status_q)) != '0) |-> $past(wr_stat)); // R8

  AST_SET_FORCES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((out_q & $past(wdata_i)) == $past(wdata_i))); // R4

  AST_CLR_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((out_q & $past(wdata_i)) == '0)); // R4

  AST_RSVD_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rsvd |=> $stable(out_q)); // R9
endmodule

bind gpio_ctrl gpio_ctrl_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_we_i   (bus_we_i),
  .wdata_i    (bus_wdata_i[NUM_PINS-1:0]),
  .out_q      (out_q),
  .status_q   (status_q),
  .irq_en_mask(irq_en_mask)
);

// File: tb/gpio_ctrl_bench.sv
module gpio_ctrl_bench;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  pin = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct { logic [31:0] exp; string req; } exp_t;
  exp_t exp_q[$];
  logic rd_mark = 1'b0;

  always #10 clk = ~clk;

  gpio_ctrl #(.NUM_PINS(N), .SYNC_STAGES(2)) u_gpio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // monitor: compare read data one cycle after each marked read
  initial begin
    logic p;
    exp_t e;
    forever begin
      @(posedge clk);
      p = rd_mark;
      @(negedge clk);
      if (p && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_tests++;
        if (rdata !== e.exp) begin
          n_fail++;
          $display("FAIL %s: read data %h expected %h", e.req, rdata, e.exp);
        end
      end
    end
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; rd_mark = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); addr = a; we = 1'b0; rd_mark = 1'b1;
    exp_q.push_back('{exp, r});
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); we = 1'b0; rd_mark = 1'b0; end
  endtask

  task automatic drive_pins(input logic [N-1:0] v);
    @(negedge clk); pin = v; we = 1'b0; rd_mark = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 pin_o", 32'(pin_out), 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    rd(8'h88, 32'h0, "R1 out");
    rd(8'h80, 32'h0, "R1 status");
    rd(8'h00, 32'h0, "R1 cfg0");
    // R2 field layout, bit 4 reads zero
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00EF, "R2 cfg2 readback");
    wr(8'h08, 32'h0);
    rd(8'h08, 32'h0, "R2 cfg2 cleared");
    // R9 reserved space
    wr(8'h24, 32'hFF);
    rd(8'h24, 32'h0, "R9 cfg above pin count");
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h8C, 32'h0, "R9 bulk cfg hole");
    wr(8'h89, 32'hFF);
    rd(8'h88, 32'h0, "R9 unaligned write ignored");
    // R3 output register and enables
    wr(8'h00, 32'h05);
    wr(8'h04, 32'h05);
    wr(8'h08, 32'h01);
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h88, 32'h0000_00FF, "R3 out readback");
    idle(1);
    check("R3 pin_o gated by bit0", 32'(pin_out), 32'h07);
    check("R3 pin_oe needs bits 0 and 2", 32'(pin_oe), 32'h03);
    // R4 set/clear
    wr(8'hA0, 32'h0F);
    rd(8'h88, 32'hF0, "R4 clear bits");
    wr(8'hA4, 32'h01);
    rd(8'h88, 32'hF1, "R4 set bits");
    rd(8'hA0, 32'h0, "R4 clear reads zero");
    rd(8'hA4, 32'h0, "R4 set reads zero");
    idle(1);
    check("R4 pin_o after set/clear", 32'(pin_out), 32'h01);
    // R5 input sync, pin4 input with rising trig but no irq enable
    wr(8'h10, 32'h42);
    drive_pins(8'hFF);
    rd(8'h84, 32'h0, "R5 not yet synchronised");
    rd(8'h84, 32'h10, "R5 synchronised, enabled pins only");
    drive_pins(8'h00);
    idle(3);
    rd(8'h80, 32'h0, "R6 irq disabled pin sets nothing");
    // R6 rising edge on pin5
    wr(8'h14, 32'h4A);
    idle(2);
    drive_pins(8'h20);
    idle(1);
    check("R6 irq after 1 edge", 32'(irq), 32'h0);
    idle(1);
    check("R6 irq after 2 edges", 32'(irq), 32'h0);
    idle(1);
    check("R6 irq after 3 edges", 32'(irq), 32'h1);
    rd(8'h80, 32'h20, "R6 rising status");
    drive_pins(8'h00);
    idle(3);
    rd(8'h80, 32'h20, "R8 sticky");
    wr(8'h80, 32'h20);
    rd(8'h80, 32'h0, "R8 w1c");
    idle(1);
    check("R8 irq low after clear", 32'(irq), 32'h0);
    // R6 falling edge on pin6
    wr(8'h18, 32'h6A);
    drive_pins(8'h40);
    idle(3);
    rd(8'h80, 32'h0, "R6 falling ignores rise");
    drive_pins(8'h00);
    idle(3);
    rd(8'h80, 32'h40, "R6 falling status");
    wr(8'h80, 32'hFF);
    // R6 both edges pin3 with pin5 rising, partial clear R8
    wr(8'h0C, 32'h8A);
    idle(2);
    drive_pins(8'h28);
    idle(3);
    rd(8'h80, 32'h28, "R6 both-edge rise plus rising");
    wr(8'h80, 32'h08);
    rd(8'h80, 32'h20, "R8 zero bits untouched");
    wr(8'h80, 32'hFF);
    drive_pins(8'h00);
    idle(3);
    rd(8'h80, 32'h08, "R6 both-edge fall");
    wr(8'h80, 32'hFF);
    rd(8'h80, 32'h0, "R8 clear all");
    // R7 level high on pin7
    wr(8'h1C, 32'h0A);
    idle(3);
    rd(8'h80, 32'h0, "R7 level high idle");
    drive_pins(8'h80);
    idle(3);
    rd(8'h80, 32'h80, "R7 level high set");
    wr(8'h80, 32'h80);
    rd(8'h80, 32'h80, "R7 level high re-set after clear");
    drive_pins(8'h00);
    idle(3);
    wr(8'h80, 32'hFF);
    rd(8'h80, 32'h0, "R7 level high released");
    // R7 level low on pin1 (also drops its output enable)
    wr(8'h04, 32'h2A);
    idle(2);
    rd(8'h80, 32'h02, "R7 level low set");
    check("R3 pin_oe after reconfig", 32'(pin_oe), 32'h01);
    drive_pins(8'h02);
    idle(3);
    wr(8'h80, 32'hFF);
    rd(8'h80, 32'h0, "R7 level low released");
    // R7 reserved trigger code 5 on pin2
    wr(8'h08, 32'hAA);
    idle(2);
    drive_pins(8'h06);
    idle(3);
    rd(8'h80, 32'h0, "R7 reserved code rise");
    drive_pins(8'h02);
    idle(3);
    rd(8'h80, 32'h0, "R7 reserved code fall");
    idle(2);
    check("R8 irq idle at end", 32'(irq), 32'h0);
    finish_run();
  end
endmodule